// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is the serial host side of a small timekeeping register file. It watches two-wire bus samples, SCL and SDA, that are already synchronised to the system clock. It answers only its own 7-bit device address. It drives a single pull-low enable toward the open-drain SDA pad. The host reaches eight byte-wide registers through a 3-bit word pointer that advances by itself after each byte.

Three transfers are supported. In a write, the host sends the device address with the direction bit at 0, then one word-address byte that loads the pointer, then any number of data bytes. In a pointer-set read, the host writes the word address, issues a repeated START and reads from that location. In a current-address read, the host reads without setting the pointer first.

The timekeeping core sees a simple register port: an address, write data, a one-cycle write strobe and a combinational read-data return. It also sees a read-active flag, which tells the core to hold off clock updates while the host is reading the clock registers. A power-fail input cancels any transfer, clears the pointer and blinds the block to the bus.

Top module: `twi_regport`

## Requirements
- R1: The block acknowledges only address bytes whose upper seven bits are 1101000 (D0h to write, D1h to read). Any other address byte gets no acknowledge, and the bytes that follow it up to the next START change neither the registers nor the pointer.
- R2: In a write, the block drives SDA low through the ninth SCL clock after the address byte, after the word-address byte and after every data byte.
- R3: The first byte after a write address loads its low three bits into the word pointer. Each later byte is written at the pointer with a one-cycle write strobe while SCL is high on its acknowledge clock.
- R4: The pointer reads 0 after reset. It increments on the acknowledge clock of each written data byte and wraps from 7 to 0.
- R5: After a repeated START and D1h, the block returns the byte at the pointer MSB first. Each bit is shifted out while SCL is low.
- R6: During reads the pointer increments only when the host drives SDA low in the ninth clock. On a host no-acknowledge the pointer is left unchanged, the block releases SDA and it stays idle until the next START.
- R7: A read that is not preceded by a pointer write starts at the address currently held in the pointer.
- R8: While the power-fail input is high, any transfer is abandoned, SDA is released, the pointer is cleared to 0 and the read-active flag is cleared. No bus activity is acknowledged and no register is written.
- R9: The read-active flag rises when a read byte is fetched from addresses 0 to 6. It stays high until STOP. A read of address 7 alone does not raise it.
- R10: SDA is sampled on the rising SCL edge, and the pull-low enable changes only while SCL is low. START is an SDA fall and STOP is an SDA rise, each seen while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| pwr_fail_i | input | 1 | Power-fail abort |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| reg_addr_o | output | 3 | Register address (word pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data at reg_addr_o |
| rd_busy_o | output | 1 | Clock registers are being read |

## Verification
Some properties are checked on every cycle. The pull-low enable only changes in a cycle that follows a low SCL sample. Every write strobe falls while SCL is high and the block is acknowledging. Each write is followed by a pointer one higher, modulo eight. Power-fail always leaves the pointer at zero with SDA released. Other behaviour needs whole transactions from the bench's bit-level master, because it depends on what the host does across many bytes. This covers data read back after writes, the 7-to-0 wrap in a burst, the pointer value left after a no-acknowledge, the start point of a current-address read, the lifetime of the read-active flag, and the absence of any effect from a foreign address or from traffic during power-fail.

// File: rtl/twi_regport.sv
module twi_regport #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter logic [DW-2:0] DEV_ID = 7'h68,
  parameter int CLK_REGS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          pwr_fail_i,
  output logic          sda_pull_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          rd_busy_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS = CW'(DW);
  localparam logic [AW-1:0] LAST_CLK = AW'(CLK_REGS - 1);
  localparam logic [1:0] K_ADR = 2'd0, K_WORD = 2'd1, K_DATA = 2'd2;

  typedef enum logic [2:0] {IDLE, RX, RACK, TX, TACK} st_t;

  st_t st;
  logic scl_q, sda_q, rw, mack, busy;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [1:0] kind;
  logic [AW-1:0] ptr;

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire bus_start = scl_i & scl_q & sda_q & ~sda_i;
  wire bus_stop = scl_i & scl_q & ~sda_q & sda_i;

  assign reg_we_o = (st == RACK) && scl_rise && (kind == K_DATA) && !pwr_fail_i;
  assign reg_addr_o = ptr;
  assign reg_wdata_o = sh;
  assign sda_pull_o = (st == RACK) | ((st == TX) & ~sh[DW-1]);
  assign rd_busy_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; scl_q <= 1'b1; sda_q <= 1'b1; rw <= 1'b0; mack <= 1'b0;
      busy <= 1'b0; sh <= '0; cnt <= '0; kind <= K_ADR; ptr <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (pwr_fail_i) begin
        st <= IDLE; ptr <= '0; busy <= 1'b0;
      end else if (bus_stop) begin
        st <= IDLE; busy <= 1'b0;
      end else if (bus_start) begin
        st <= RX; kind <= K_ADR; cnt <= '0;
      end else begin
        case (st)
          RX:
            if (scl_rise) begin
              sh <= {sh[DW-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              cnt <= '0;
              if (kind != K_ADR) st <= RACK;
              else if (sh[DW-1:1] == DEV_ID) begin
                st <= RACK; rw <= sh[0];
              end else st <= IDLE;
            end
          RACK:
            if (scl_rise) begin
              if (kind == K_WORD) ptr <= sh[AW-1:0];
              else if (kind == K_DATA) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (kind == K_ADR && rw) begin
                st <= TX; sh <= reg_rdata_i;
                if (ptr <= LAST_CLK) busy <= 1'b1;
              end else begin
                st <= RX;
                kind <= (kind == K_ADR) ? K_WORD : K_DATA;
              end
            end
          TX:
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == BITS) begin
                st <= TACK; cnt <= '0;
              end else sh <= {sh[DW-2:0], 1'b1};
            end
          TACK:
            if (scl_rise) begin
              mack <= ~sda_i;
              if (!sda_i) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                st <= TX; sh <= reg_rdata_i;
                if (ptr <= LAST_CLK) busy <= 1'b1;
              end else st <= IDLE;
            end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          pwr_fail_i,
  input logic          sda_pull_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o,
  input logic          rd_busy_o
);
  p_pf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> (reg_addr_o == '0 && !sda_pull_o && !rd_busy_o));

  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> (!$past(scl_i) || $past(pwr_fail_i)));

  p_we_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (sda_pull_o && scl_i && !pwr_fail_i));

  p_we_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));

  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_busy_o) |-> !$past(scl_i));
endmodule

bind twi_regport twi_regport_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_twi_regport.sv
module test_twi_regport;
  localparam int CLK_PERIOD = 10;
  localparam int H = 4;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, pwr_fail = 1'b0;
  logic sda_pull, we, busy;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [8];
  logic [7:0] exp_m [8];
  wire sda_bus = sda_m & ~sda_pull;
  int checks = 0, fails = 0, unstable = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_regport i_twi_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .pwr_fail_i(pwr_fail),
    .sda_pull_o(sda_pull), .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_rdata_i(rdata), .rd_busy_o(busy));

  assign rdata = mem[addr];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 8; i++) mem[i] <= 8'h00;
    else if (we) mem[addr] <= wdata;
  end

  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'h59}, {3'd1, 8'h30}, {3'd2, 8'h12},
    {3'd4, 8'h25}, {3'd5, 8'h09}, {3'd7, 8'hA5}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1; hw(H); scl_m = 1; hw(H); sda_m = 0; hw(H); scl_m = 0; hw(H);
  endtask

  task automatic bstop();
    sda_m = 0; hw(H); scl_m = 1; hw(H); sda_m = 1; hw(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1; hw(H); scl_m = 0;
    end
    sda_m = 1; hw(H); scl_m = 1; hw(2); ack = sda_bus; hw(2); scl_m = 0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hw(H); scl_m = 1; hw(1); d[i] = sda_bus; hw(H - 1);
      if (sda_bus !== d[i]) unstable++;
      scl_m = 0;
    end
    sda_m = nack; hw(H); scl_m = 1; hw(H); scl_m = 0; sda_m = 1;
  endtask

  task automatic read_at(input logic [2:0] a, output logic [7:0] d, output logic [2:0] acks);
    logic k;
    bstart(); wbyte(8'hD0, k); acks[0] = k; wbyte({5'd0, a}, k); acks[1] = k;
    bstart(); wbyte(8'hD1, k); acks[2] = k; rbyte(1'b1, d); bstop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d;
    logic [2:0] ra;
    for (int i = 0; i < 8; i++) exp_m[i] = 8'h00;
    hw(3); rst_n = 1; hw(2);

    chk("R4 reset pointer", addr, 0);
    chk("R8 reset pull", sda_pull, 0);
    chk("R9 reset busy", busy, 0);
    chk("R3 reset strobe", we, 0);

    for (int v = 0; v < 6; v++) begin
      bstart(); wbyte(8'hD0, a0); wbyte({5'd0, VEC[v][10:8]}, a1); wbyte(VEC[v][7:0], a2); bstop();
      exp_m[VEC[v][10:8]] = VEC[v][7:0];
      chk("R2 write acks", {a0, a1, a2}, 3'b000);
      unstable = 0;
      read_at(VEC[v][10:8], d, ra);
      chk("R5 readback", d, exp_m[VEC[v][10:8]]);
      chk("R10 sda stable high", unstable, 0);
      chk("R6 nack keeps pointer", addr, VEC[v][10:8]);
    end

    bstart(); wbyte(8'hA0, a0); chk("R1 foreign addr nack", a0, 1);
    wbyte(8'h03, a1); wbyte(8'hEE, a2); bstop();
    chk("R1 foreign bytes nack", {a1, a2}, 2'b11);
    chk("R1 pointer untouched", addr, 7);
    bstart(); wbyte(8'hD2, a0); bstop();
    chk("R1 near addr nack", a0, 1);

    bstart(); wbyte(8'hD0, a0); wbyte(8'h06, a1);
    wbyte(8'h11, a2); wbyte(8'h22, a3); wbyte(8'h33, a0); bstop();
    exp_m[6] = 8'h11; exp_m[7] = 8'h22; exp_m[0] = 8'h33;
    chk("R4 wrap pointer", addr, 1);

    bstart(); wbyte(8'hD0, a0); wbyte(8'h06, a1); bstart(); wbyte(8'hD1, a2);
    chk("R5 read addr ack", a2, 0);
    rbyte(1'b0, d); chk("R5 burst byte0", d, 8'h11);
    chk("R9 busy during read", busy, 1);
    rbyte(1'b0, d); chk("R5 burst byte1", d, 8'h22);
    rbyte(1'b1, d); chk("R4 burst wrap byte", d, 8'h33);
    chk("R6 ack-only increments", addr, 0);
    bstop();
    chk("R9 busy cleared by stop", busy, 0);

    bstart(); wbyte(8'hD1, a0); chk("R7 current read ack", a0, 0);
    rbyte(1'b0, d); chk("R7 current read byte", d, exp_m[0]);
    rbyte(1'b1, d); chk("R7 current read next", d, exp_m[1]);
    bstop();
    chk("R6 pointer after current read", addr, 1);

    bstart(); wbyte(8'hD0, a0); wbyte(8'h07, a1); bstop();
    chk("R3 word loads pointer", addr, 7);
    bstart(); wbyte(8'hD1, a0); rbyte(1'b1, d);
    chk("R9 addr7 read data", d, exp_m[7]);
    chk("R9 addr7 no busy", busy, 0);
    bstop();

    read_at(3'd3, d, ra);
    chk("R1 foreign write had no effect", d, exp_m[3]);

    bstart(); wbyte(8'hD0, a0); wbyte(8'h05, a1);
    chk("R8 pointer before fail", addr, 5);
    pwr_fail = 1; hw(2);
    chk("R8 pointer cleared", addr, 0);
    chk("R8 sda released", sda_pull, 0);
    wbyte(8'h44, a2); bstop();
    bstart(); wbyte(8'hD0, a0); wbyte(8'h03, a1); wbyte(8'h44, a3); bstop();
    chk("R8 bus ignored", {a0, a1, a2, a3}, 4'b1111);
    pwr_fail = 0; hw(H);
    chk("R8 pointer still zero", addr, 0);
    read_at(3'd3, d, ra);
    chk("R8 no write during fail", d, exp_m[3]);
    chk("R8 bus live after fail", ra, 3'b000);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule